// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block walks a chain of 8-byte descriptors held in memory and moves data between memory and a word stream. Software, or a neighbouring controller, presents a chain base address on `desc_base`, selects the direction on `dir_to_mem`, and pulses `start`. The engine then reads each descriptor as two 32-bit words. The first word carries the flags, the action and the byte length. The second word carries a buffer address.

Transfer descriptors move `ceil(length/4)` 32-bit words. In the memory-to-stream direction the words go out on `tx_*`. In the stream-to-memory direction the words come in on `rx_*` and are written to consecutive addresses. Link descriptors redirect the walk to a new descriptor address. No-op and reserved actions are skipped. A descriptor with its end flag stops the walk after that descriptor has finished. A descriptor whose valid flag is clear aborts the walk with an error pulse.

The memory side is a request/response bus. A request is offered with `mem_req_valid` and taken when `mem_req_ready` is high at a clock edge. A read request is always held, with the same address, until it is taken. Each read is answered by exactly one `mem_rsp_valid` cycle, in order. The engine never has more than one read outstanding and issues no request while a response is pending. Writes get no response.

`tx_valid` stays high, with `tx_data` stable, until `tx_ready` takes the word. `rx_ready` is high only in a cycle where the matching memory write is taken, so a word is consumed exactly when it is written. The rx source should hold `rx_data` while `rx_valid` is high, but the engine does not depend on `rx_valid` being held.

Top module: `adma_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req_valid`, `tx_valid`, `rx_ready`, `data_done`, `dma_irq` and `adma_err` are all low.
- R2: Each descriptor is fetched as two reads, first at its address (attribute word) and then at address+4 (buffer address). Attribute bit 0 is valid, bit 1 is end, bit 2 is interrupt, bits 5:4 are the action (0 no-op, 1 reserved, 2 transfer, 3 link) and bits 31:16 are the byte length.
- R3: In the memory-to-stream direction (`dir_to_mem`=0), a transfer descriptor reads `ceil(length/4)` words from consecutive word addresses starting at its buffer address. It emits them on `tx_data` in address order.
- R4: In the stream-to-memory direction (`dir_to_mem`=1), a transfer descriptor writes `ceil(length/4)` consumed `rx_data` words to consecutive word addresses starting at its buffer address.
- R5: A length field of 0 in a transfer descriptor means 65536 bytes (16384 words).
- R6: A link descriptor moves no data, and the next descriptor is fetched from its address word.
- R7: No-op and reserved-action descriptors move no data, and the next descriptor is fetched at the current address+8. After a transfer descriptor the next descriptor is also at address+8.
- R8: A descriptor with the valid bit clear stops the walk and pulses `adma_err` for one cycle; `data_done` stays low.
- R9: A valid descriptor with the end bit set ends the walk once its data has moved. `data_done` pulses for one cycle, and `dma_irq` pulses in the same cycle only if that descriptor's interrupt bit is set.
- R10: A read request keeps `mem_req_valid` and `mem_req_addr` stable until taken. `tx_valid` and `tx_data` stay stable until `tx_ready`.
- R11: At most one read is outstanding, and no request is offered in a cycle where a response is being delivered.
- R12: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at `desc_base` (idle only) |
| dir_to_mem | input | 1 | 1: stream to memory, 0: memory to stream |
| desc_base | input | ADDR_W | Address of the first descriptor |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_we | output | 1 | 1 for a write request |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_rdata | input | 32 | Read response data |
| tx_valid | output | 1 | Outgoing word present |
| tx_ready | input | 1 | Outgoing word taken |
| tx_data | output | 32 | Outgoing word |
| rx_valid | input | 1 | Incoming word present |
| rx_ready | output | 1 | Incoming word consumed |
| rx_data | input | 32 | Incoming word |
| busy | output | 1 | Walk in progress |
| data_done | output | 1 | One-cycle pulse: chain finished at an end descriptor |
| dma_irq | output | 1 | One-cycle pulse: finished descriptor requested an interrupt |
| adma_err | output | 1 | One-cycle pulse: invalid descriptor met |

## Verification
The bench uses the default `ADDR_W` of 32. Because the length field is fixed at 16 bits, the 65536-byte case is only 16384 word beats, so it can run in full alongside a sweep of every transfer length from 1 to 12 bytes in both directions. In that sweep each chain mixes a no-op or reserved head, a link, and two transfers whose word counts cross the rounding boundary. Ready and valid lines on every handshake are driven from a pseudo-random pattern, so stalls land on every state.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;
  localparam int CNT_W  = LEN_W - 1;

  typedef enum logic [1:0] {
    ACT_NOP  = 2'd0,
    ACT_RSV  = 2'd1,
    ACT_XFER = 2'd2,
    ACT_LINK = 2'd3
  } act_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    act_e             act;
    logic             irq;
    logic             last;
    logic             valid;
  } desc_attr_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ATTR_REQ, S_ATTR_WAIT, S_ADDR_REQ, S_ADDR_WAIT,
    S_RD_REQ, S_RD_WAIT, S_PUSH, S_WR, S_STEP
  } st_e;
endpackage

// File: rtl/adma_desc_decode.sv
module adma_desc_decode
  import adma_pkg::*;
(
  input  desc_attr_t       attr,
  output logic             is_xfer,
  output logic             is_link,
  output logic [CNT_W-1:0] words
);
  localparam logic [CNT_W-1:0] FULL_WORDS = CNT_W'(1) << (LEN_W - 2);

  assign is_xfer = (attr.act == ACT_XFER);
  assign is_link = (attr.act == ACT_LINK);
  // A zero length encodes the full 2^LEN_W bytes
  assign words = (attr.len == '0) ? FULL_WORDS
               : CNT_W'(((LEN_W+1)'(attr.len) + (LEN_W+1)'(3)) >> 2);
endmodule

// File: rtl/adma_xfer_ctr.sv
module adma_xfer_ctr #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_words,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      addr   <= '0;
    end else if (load) begin
      left_q <= load_words;
      addr   <= load_addr;
    end else if (step) begin
      left_q <= left_q - CNT_W'(1);
      addr   <= addr + ADDR_W'(4);
    end
  end

  assign last = (left_q == CNT_W'(1));

  // R3
  step_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (left_q != '0));
endmodule

// File: rtl/adma_engine.sv
module adma_engine
  import adma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_to_mem,
  input  logic [ADDR_W-1:0] desc_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [WORD_W-1:0] rx_data,
  output logic              busy,
  output logic              data_done,
  output logic              dma_irq,
  output logic              adma_err
);
  localparam logic [ADDR_W-1:0] DESC_BYTES = ADDR_W'(8);

  st_e               state;
  desc_attr_t        attr_q;
  logic [ADDR_W-1:0] desc_addr;
  logic [WORD_W-1:0] data_q;
  logic              dir_q;
  logic              is_xfer, is_link;
  logic [CNT_W-1:0]  words;
  logic              ctr_load, ctr_step, ctr_last;
  logic [ADDR_W-1:0] ctr_addr;
  logic              rd_beat, wr_beat;

  adma_desc_decode u_dec (
    .attr(attr_q), .is_xfer(is_xfer), .is_link(is_link), .words(words)
  );

  adma_xfer_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_addr(mem_rsp_rdata[ADDR_W-1:0]),
    .load_words(words), .step(ctr_step), .addr(ctr_addr), .last(ctr_last)
  );

  assign rd_beat  = (state == S_PUSH) && tx_ready;
  assign wr_beat  = (state == S_WR) && rx_valid && mem_req_ready;
  assign ctr_step = rd_beat || wr_beat;
  assign ctr_load = (state == S_ADDR_WAIT) && mem_rsp_valid && attr_q.valid && is_xfer;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_addr  = ctr_addr;
    unique case (state)
      S_ATTR_REQ: begin mem_req_valid = 1'b1; mem_req_addr = desc_addr; end
      S_ADDR_REQ: begin mem_req_valid = 1'b1; mem_req_addr = desc_addr + ADDR_W'(4); end
      S_RD_REQ:   mem_req_valid = 1'b1;
      S_WR:       mem_req_valid = rx_valid;
      default:    ;
    endcase
  end

  assign mem_req_we    = (state == S_WR);
  assign mem_req_wdata = rx_data;
  assign rx_ready      = wr_beat;
  assign tx_valid      = (state == S_PUSH);
  assign tx_data       = data_q;
  assign busy          = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      attr_q    <= '0;
      desc_addr <= '0;
      data_q    <= '0;
      dir_q     <= 1'b0;
      data_done <= 1'b0;
      dma_irq   <= 1'b0;
      adma_err  <= 1'b0;
    end else begin
      data_done <= 1'b0;
      dma_irq   <= 1'b0;
      adma_err  <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          desc_addr <= desc_base;
          dir_q     <= dir_to_mem;
          state     <= S_ATTR_REQ;
        end
        S_ATTR_REQ: if (mem_req_ready) state <= S_ATTR_WAIT;
        S_ATTR_WAIT: if (mem_rsp_valid) begin
          attr_q <= '{len: mem_rsp_rdata[31:16], act: act_e'(mem_rsp_rdata[5:4]),
                      irq: mem_rsp_rdata[2], last: mem_rsp_rdata[1], valid: mem_rsp_rdata[0]};
          state  <= S_ADDR_REQ;
        end
        S_ADDR_REQ: if (mem_req_ready) state <= S_ADDR_WAIT;
        S_ADDR_WAIT: if (mem_rsp_valid) begin
          if (!attr_q.valid) begin
            adma_err <= 1'b1;
            state    <= S_IDLE;
          end else if (is_link) begin
            desc_addr <= mem_rsp_rdata[ADDR_W-1:0];
            state     <= S_STEP;
          end else begin
            desc_addr <= desc_addr + DESC_BYTES;
            state     <= !is_xfer ? S_STEP : (dir_q ? S_WR : S_RD_REQ);
          end
        end
        S_RD_REQ: if (mem_req_ready) state <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) begin
          data_q <= mem_rsp_rdata;
          state  <= S_PUSH;
        end
        S_PUSH: if (tx_ready) state <= ctr_last ? S_STEP : S_RD_REQ;
        S_WR:   if (wr_beat && ctr_last) state <= S_STEP;
        S_STEP: if (attr_q.last) begin
          data_done <= 1'b1;
          dma_irq   <= attr_q.irq;
          state     <= S_IDLE;
        end else begin
          state <= S_ATTR_REQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !mem_req_we) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R11
  one_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid);
  // R9
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq |-> data_done);
  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adma_err |-> !data_done);
  // R9
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (data_done || adma_err));
endmodule

// File: tb/adma_engine_tb.sv
module adma_engine_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_to_mem = 1'b0;
  logic [31:0] desc_base = '0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [31:0] rx_data = 32'hC0DE0000;
  logic        busy, data_done, dma_irq, adma_err;

  always #(CLK_P/2) clk = ~clk;

  adma_engine #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_to_mem(dir_to_mem), .desc_base(desc_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .busy(busy), .data_done(data_done), .dma_irq(dma_irq), .adma_err(adma_err)
  );

  int tests = 0, fails = 0;
  logic [31:0] desc_mem [0:255];
  logic [31:0] seg_a [0:3];
  int seg_w [0:3];
  int nseg = 0, s = 0, off = 0, beats = 0, mism = 0, proto = 0, dreads = 0;
  int n_done = 0, n_irq = 0, n_err = 0;
  logic        pend = 1'b0, rx_taken = 1'b0, rx_hold = 1'b0;
  logic [31:0] pend_addr = '0;
  logic [15:0] lfsr = 16'hACE1;
  int          rx_seq = 0;

  function automatic logic [31:0] datf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0F0F1234;
  endfunction

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    return (a < 32'h400) ? desc_mem[a[9:2]] : datf(a);
  endfunction

  // bit 0 valid, bit 1 end, bit 2 interrupt, bits 5:4 action, bits 31:16 length
  function automatic logic [31:0] mk(input bit v, input bit e, input bit i,
                                     input logic [1:0] act, input logic [15:0] len);
    return {len, 10'd0, act, 1'b0, i, e, v};
  endfunction

  task automatic put_desc(input logic [31:0] at, input logic [31:0] attr, input logic [31:0] a);
    desc_mem[at[9:2]]     = attr;
    desc_mem[at[9:2] + 1] = a;
  endtask

  task automatic beat(input logic [31:0] a, input logic [31:0] d, input bit chk_data);
    logic [31:0] ea;
    if (s >= nseg) mism++;
    else begin
      ea = seg_a[s] + 32'(4 * off);
      if (!chk_data && a !== ea) mism++;
      if (chk_data && d !== datf(ea)) mism++;
      off++; beats++;
      if (off == seg_w[s]) begin s++; off = 0; end
    end
  endtask

  // memory model, stream drivers and monitor
  always @(negedge clk) begin
    mem_rsp_valid = pend;
    mem_rsp_rdata = rd_fn(pend_addr);
    pend = 1'b0;
    if (rx_taken) begin rx_seq++; rx_data = 32'hC0DE0000 + 32'(rx_seq); end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready = lfsr[0] | lfsr[3];
    tx_ready      = lfsr[5] | lfsr[7];
    rx_valid      = rx_hold | lfsr[9] | lfsr[11];
    #(CLK_P/4);
    rx_taken = 1'b0;
    if (rst_n) begin
      if (mem_req_valid && mem_rsp_valid) proto++;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          rx_taken = 1'b1;
          if (mem_req_wdata !== rx_data || !rx_ready) mism++;
          beat(mem_req_addr, 32'd0, 1'b0);
        end else begin
          pend = 1'b1;
          pend_addr = mem_req_addr;
          if (mem_req_addr < 32'h400) dreads++;
        end
      end
      if (tx_valid && tx_ready) beat(32'd0, tx_data, 1'b1);
      rx_hold = rx_valid && !rx_ready;
      if (data_done) n_done++;
      if (dma_irq) n_irq++;
      if (adma_err) n_err++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_run();
    nseg = 0; s = 0; off = 0; beats = 0; mism = 0; proto = 0; dreads = 0;
    n_done = 0; n_irq = 0; n_err = 0;
  endtask

  task automatic add_seg(input logic [31:0] a, input int w);
    seg_a[nseg] = a; seg_w[nseg] = w; nseg++;
  endtask

  task automatic run(input logic [31:0] base, input bit dir, input bit poke);
    @(negedge clk);
    desc_base = base; dir_to_mem = dir; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R12: a second start while busy, pointing at an invalid descriptor
      @(negedge clk); desc_base = 32'h088; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 60000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic verify(input string req, input int exp_done, input int exp_irq,
                        input int exp_err, input int exp_dreads);
    int tot = 0;
    for (int k = 0; k < nseg; k++) tot += seg_w[k];
    chk(!busy, req, "busy after run", int'(busy), 0);
    chk(beats == tot, req, "data beats", beats, tot);
    chk(mism == 0, req, "address/data mismatches", mism, 0);
    chk(n_done == exp_done, "R9", "data_done pulses", n_done, exp_done);
    chk(n_irq == exp_irq, "R9", "dma_irq pulses", n_irq, exp_irq);
    chk(n_err == exp_err, "R8", "adma_err pulses", n_err, exp_err);
    chk(dreads == exp_dreads, "R2", "descriptor reads", dreads, exp_dreads);
    chk(proto == 0, "R11", "request during response", proto, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) desc_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !mem_req_valid && !tx_valid && !rx_ready, "R1", "idle outputs in reset",
        int'({busy, mem_req_valid, tx_valid, rx_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !data_done && !dma_irq && !adma_err, "R1", "idle outputs after reset",
        int'({busy, data_done, dma_irq, adma_err}), 0);

    // R3 R4 R6 R7: sweep of lengths in both directions
    for (int d = 0; d < 2; d++) begin
      for (int len = 1; len <= 12; len++) begin
        clear_run();
        put_desc(32'h000, mk(1, 0, 0, (len % 2) ? 2'd1 : 2'd0, 16'd0), 32'h1234);
        put_desc(32'h008, mk(1, 0, 0, 2'd3, 16'd0), 32'h100);
        put_desc(32'h100, mk(1, 0, 0, 2'd2, 16'(len)), 32'h1000_0000 + 32'(len * 256));
        put_desc(32'h108, mk(1, 1, 1, 2'd2, 16'(len + 5)), 32'h2000_0000);
        add_seg(32'h1000_0000 + 32'(len * 256), (len + 3) / 4);
        add_seg(32'h2000_0000, (len + 8) / 4);
        run(32'h000, d[0], 1'b0);
        verify(d ? "R4" : "R3", 1, 1, 0, 8);
      end
    end

    // R9: end without interrupt flag
    clear_run();
    put_desc(32'h040, mk(1, 1, 0, 2'd2, 16'd8), 32'h3000_0000);
    add_seg(32'h3000_0000, 2);
    run(32'h040, 1'b0, 1'b0);
    verify("R9", 1, 0, 0, 2);

    // R8: invalid descriptor after a good transfer
    clear_run();
    put_desc(32'h080, mk(1, 0, 1, 2'd2, 16'd4), 32'h4000_0000);
    put_desc(32'h088, mk(0, 1, 1, 2'd2, 16'd4), 32'h4100_0000);
    add_seg(32'h4000_0000, 1);
    run(32'h080, 1'b1, 1'b0);
    verify("R8", 0, 0, 1, 4);

    // R6: link carrying the end flag finishes with no data
    clear_run();
    put_desc(32'h0E0, mk(1, 1, 1, 2'd3, 16'd0), 32'h088);
    run(32'h0E0, 1'b0, 1'b0);
    verify("R6", 1, 1, 0, 2);

    // R12: start while busy is ignored
    clear_run();
    put_desc(32'h040, mk(1, 1, 1, 2'd2, 16'd24), 32'h5000_0000);
    add_seg(32'h5000_0000, 6);
    run(32'h040, 1'b0, 1'b1);
    verify("R12", 1, 1, 0, 2);

    // R5: zero length means 65536 bytes
    clear_run();
    put_desc(32'h0C0, mk(1, 1, 1, 2'd2, 16'd0), 32'h6000_0000);
    add_seg(32'h6000_0000, 16384);
    run(32'h0C0, 1'b1, 1'b0);
    verify("R5", 1, 1, 0, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 180000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule